// File: doc/BRIEF.md
# Timer Control Access Outcome Decoder

This block decides what happens when software at a given privilege level reads or writes the physical timer control register. Its inputs are the current level (0 to 3), a flag for each of levels 1, 2 and 3 saying whether that level runs in the 32-bit execution state, and a flag saying whether level 3 exists. It also takes the hypervisor-enabled flag, the hypervisor's host-mode bits (E2H, TGE), the secure/non-secure bit, and six access-enable bits. The enable bits come from the kernel (32-bit and 64-bit views) and from the hypervisor (32-bit and 64-bit views).

A fixed-priority chain of conditions is walked, and the first match wins. The result is one of four outcomes: a trap to level 1, a trap to level 2, a 32-bit hypervisor trap, or an undefined access. A permitted access instead reaches one of five banked copies of the register. The decision is held in a single state register, so it appears one clock after the request inputs. A one-hot outcome vector and an 8-bit trap code are driven from that state. The read/write direction bit passes through with the same one-cycle delay. Register storage and exception entry belong to the surrounding logic.

The state register has nine named states, and each state is also a bit position of the outcome vector:

| Bit | State | Meaning |
|-----|-------|---------|
| 0 | OC_TRAP_L1 | trap to level 1 |
| 1 | OC_TRAP_L2 | trap to level 2 (64-bit hypervisor) |
| 2 | OC_TRAP_HYP32 | trap to the 32-bit hypervisor |
| 3 | OC_UNDEF | undefined access |
| 4 | OC_BANK_COMMON | the common copy |
| 5 | OC_BANK_SEC | the secure banked copy |
| 6 | OC_BANK_NSEC | the non-secure banked copy |
| 7 | OC_BANK_L2SEC | the secure level-2 copy |
| 8 | OC_BANK_L2NSEC | the non-secure level-2 copy |

Transitions: on every clock the state moves to the decision for the current inputs, from any state to any state. Reset forces OC_UNDEF.

Terms used below:
- "64-bit hypervisor" means hyp_en=1 and l2_aa32=0.
- "32-bit hypervisor" means hyp_en=1 and l2_aa32=1.
- "Host mode" means hyp_en=1 and {e2h,tge}=11.

Top module: `ptimer_trap_decoder`

## Requirements
- R1: After reset, and until the first clock edge that follows the release of reset, outcome is 9'h008 (OC_UNDEF), trap_code is 0 and wr_out is 0. After that, every output reflects the inputs sampled at the previous rising clock edge.
- R2: At level 0, the access traps with code 0x03 when all of these hold: l1_aa32=0, host mode is not active, and k64_el0_ten=0. The target is level 2 (bit 1) if the hypervisor is 64-bit and tge=1, and level 1 (bit 0) otherwise.
- R3: At level 0, with l1_aa32=1 and k32_el0_ten=0, the first match below decides:
  - with a 64-bit hypervisor and tge=1, a level-2 trap (bit 1) with code 0x03;
  - with a 32-bit hypervisor and tge=1, a 32-bit hypervisor trap (bit 2) with code 0x00;
  - otherwise undefined (bit 3) with code 0.
- R4: At levels 0 and 1, with a 64-bit hypervisor, e2h=0 and h64_el1_cen=0, the access traps to level 2 (bit 1) with code 0x03.
- R5: With a 64-bit hypervisor, a clear timer-access enable traps the access to level 2 (bit 1) with code 0x03. The enable that applies depends on the level and the host-mode bits:
  - at level 0 with {e2h,tge}=10, it is h64_el1_ten;
  - at level 1 with e2h=1, it is h64_el1_ten;
  - at level 0 with {e2h,tge}=11, it is h64_el0_ten.
- R6: At levels 0 and 1, with a 32-bit hypervisor and h32_el1_cen=0, the access gives a 32-bit hypervisor trap (bit 2) with code 0x03.
- R7: At level 0, a permitted access in host mode with a 64-bit hypervisor reaches bit 7 when ns=0 and bit 8 when ns=1. Any other permitted level-0 access reaches bit 4.
- R8: At level 1, a permitted access reaches bit 5 (ns=0) or bit 6 (ns=1) when l3_present=1 and l3_aa32=1. Otherwise it reaches bit 4.
- R9: At level 2, the access reaches bit 6 when l3_present=1 and l3_aa32=1, and bit 4 otherwise. At level 3, it reaches bit 5 when ns=0 and bit 6 when ns=1.
- R10: Exactly one outcome bit is set in every cycle. trap_code is 0 whenever none of bits 0 to 2 is set.
- R11: wr_out equals wr_in delayed by one clock. The direction has no effect on outcome or trap_code.
- R12: The conditions are tried in the order R2, R3, R4, R5, R6, then banking, and the first match decides. For example, at level 0 an R2 trap to level 1 is taken even when the R4 condition also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cur_el | input | 2 | current privilege level |
| l1_aa32 | input | 1 | level 1 runs in the 32-bit state |
| l2_aa32 | input | 1 | level 2 runs in the 32-bit state |
| l3_aa32 | input | 1 | level 3 runs in the 32-bit state |
| l3_present | input | 1 | level 3 is implemented |
| hyp_en | input | 1 | hypervisor enabled |
| e2h | input | 1 | hypervisor host-extension bit |
| tge | input | 1 | hypervisor trap-general bit |
| ns | input | 1 | non-secure state |
| k64_el0_ten | input | 1 | kernel (64-bit view) level-0 timer-access enable |
| k32_el0_ten | input | 1 | kernel (32-bit view) level-0 timer-access enable |
| h64_el1_cen | input | 1 | hypervisor (64-bit view) level-1 counter-access enable |
| h64_el1_ten | input | 1 | hypervisor (64-bit view) level-1 timer-access enable |
| h64_el0_ten | input | 1 | hypervisor (64-bit view) level-0 timer-access enable |
| h32_el1_cen | input | 1 | hypervisor (32-bit view) level-1 counter-access enable |
| wr_in | input | 1 | access direction, 1 = write |
| outcome | output | 9 | one-hot decision |
| trap_code | output | 8 | trap code, 0 if no trap |
| wr_out | output | 1 | direction, delayed one clock |

## Verification
A wrong next-state choice shows up as the wrong outcome bit, or a wrong trap code, one clock after the offending inputs. Nothing persists across requests, so each fault appears on exactly one sampled cycle and can be tied directly to the input vector that caused it. Faults in priority order only appear when two rules match at once. For that reason, random vectors are combined with directed cases that make earlier and later rules match together.

// File: rtl/ptimer_trap_pkg.sv
package ptimer_trap_pkg;

    localparam int CODE_W = 8;
    localparam int NUM_OC = 9;
    localparam int OC_W   = $clog2(NUM_OC);

    typedef enum logic [OC_W-1:0] {
        OC_TRAP_L1     = 4'd0,
        OC_TRAP_L2     = 4'd1,
        OC_TRAP_HYP32  = 4'd2,
        OC_UNDEF       = 4'd3,
        OC_BANK_COMMON = 4'd4,
        OC_BANK_SEC    = 4'd5,
        OC_BANK_NSEC   = 4'd6,
        OC_BANK_L2SEC  = 4'd7,
        OC_BANK_L2NSEC = 4'd8
    } outcome_e;

    localparam logic [CODE_W-1:0] CODE_TIMER  = CODE_W'(3);
    localparam logic [CODE_W-1:0] CODE_HYPTGE = CODE_W'(0);
    localparam logic [CODE_W-1:0] CODE_NONE   = CODE_W'(0);

    typedef struct packed {
        outcome_e              oc;
        logic [CODE_W-1:0]     code;
    } verdict_t;

endpackage

// File: rtl/ptimer_el0_dec.sv
module ptimer_el0_dec
    import ptimer_trap_pkg::*;
(
    input  logic     l1_aa32,
    input  logic     l2_aa32,
    input  logic     hyp_en,
    input  logic     e2h,
    input  logic     tge,
    input  logic     ns,
    input  logic     k64_el0_ten,
    input  logic     k32_el0_ten,
    input  logic     h64_el1_cen,
    input  logic     h64_el1_ten,
    input  logic     h64_el0_ten,
    input  logic     h32_el1_cen,
    output verdict_t verdict
);

    logic hyp64;
    logic hyp32;
    logic host;

    assign hyp64 = hyp_en & ~l2_aa32;
    assign hyp32 = hyp_en &  l2_aa32;
    assign host  = hyp_en & e2h & tge;

    always_comb begin
        verdict = '{oc: OC_BANK_COMMON, code: CODE_NONE};
        if (!l1_aa32 && !host && !k64_el0_ten) begin
            if (hyp64 && tge) verdict = '{oc: OC_TRAP_L2, code: CODE_TIMER};
            else              verdict = '{oc: OC_TRAP_L1, code: CODE_TIMER};
        end else if (l1_aa32 && !k32_el0_ten) begin
            if (hyp64 && tge)      verdict = '{oc: OC_TRAP_L2,    code: CODE_TIMER};
            else if (hyp32 && tge) verdict = '{oc: OC_TRAP_HYP32, code: CODE_HYPTGE};
            else                   verdict = '{oc: OC_UNDEF,      code: CODE_NONE};
        end else if (hyp64 && !e2h && !h64_el1_cen) begin
            verdict = '{oc: OC_TRAP_L2, code: CODE_TIMER};
        end else if (hyp64 && e2h && !tge && !h64_el1_ten) begin
            verdict = '{oc: OC_TRAP_L2, code: CODE_TIMER};
        end else if (hyp64 && e2h && tge && !h64_el0_ten) begin
            verdict = '{oc: OC_TRAP_L2, code: CODE_TIMER};
        end else if (hyp32 && !h32_el1_cen) begin
            verdict = '{oc: OC_TRAP_HYP32, code: CODE_TIMER};
        end else if (hyp64 && e2h && tge) begin
            verdict = ns ? '{oc: OC_BANK_L2NSEC, code: CODE_NONE}
                         : '{oc: OC_BANK_L2SEC,  code: CODE_NONE};
        end
    end

endmodule

// File: rtl/ptimer_el1_dec.sv
module ptimer_el1_dec
    import ptimer_trap_pkg::*;
(
    input  logic     l2_aa32,
    input  logic     l3_aa32,
    input  logic     l3_present,
    input  logic     hyp_en,
    input  logic     e2h,
    input  logic     ns,
    input  logic     h64_el1_cen,
    input  logic     h64_el1_ten,
    input  logic     h32_el1_cen,
    output verdict_t verdict
);

    logic hyp64;
    logic hyp32;

    assign hyp64 = hyp_en & ~l2_aa32;
    assign hyp32 = hyp_en &  l2_aa32;

    always_comb begin
        verdict = '{oc: OC_BANK_COMMON, code: CODE_NONE};
        if (hyp64 && !e2h && !h64_el1_cen) begin
            verdict = '{oc: OC_TRAP_L2, code: CODE_TIMER};
        end else if (hyp64 && e2h && !h64_el1_ten) begin
            verdict = '{oc: OC_TRAP_L2, code: CODE_TIMER};
        end else if (hyp32 && !h32_el1_cen) begin
            verdict = '{oc: OC_TRAP_HYP32, code: CODE_TIMER};
        end else if (l3_present && l3_aa32) begin
            verdict = ns ? '{oc: OC_BANK_NSEC, code: CODE_NONE}
                         : '{oc: OC_BANK_SEC,  code: CODE_NONE};
        end
    end

endmodule

// File: rtl/ptimer_upper_dec.sv
module ptimer_upper_dec
    import ptimer_trap_pkg::*;
(
    input  logic     at_l3,
    input  logic     l3_aa32,
    input  logic     l3_present,
    input  logic     ns,
    output verdict_t verdict
);

    always_comb begin
        if (at_l3) begin
            verdict = ns ? '{oc: OC_BANK_NSEC, code: CODE_NONE}
                         : '{oc: OC_BANK_SEC,  code: CODE_NONE};
        end else if (l3_present && l3_aa32) begin
            verdict = '{oc: OC_BANK_NSEC, code: CODE_NONE};
        end else begin
            verdict = '{oc: OC_BANK_COMMON, code: CODE_NONE};
        end
    end

endmodule

// File: rtl/ptimer_trap_decoder.sv
module ptimer_trap_decoder
    import ptimer_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_el,
    input  logic              l1_aa32,
    input  logic              l2_aa32,
    input  logic              l3_aa32,
    input  logic              l3_present,
    input  logic              hyp_en,
    input  logic              e2h,
    input  logic              tge,
    input  logic              ns,
    input  logic              k64_el0_ten,
    input  logic              k32_el0_ten,
    input  logic              h64_el1_cen,
    input  logic              h64_el1_ten,
    input  logic              h64_el0_ten,
    input  logic              h32_el1_cen,
    input  logic              wr_in,
    output logic [NUM_OC-1:0] outcome,
    output logic [CODE_W-1:0] trap_code,
    output logic              wr_out
);

    verdict_t v_l0;
    verdict_t v_l1;
    verdict_t v_up;
    verdict_t v_next;

    outcome_e          state_q;
    logic [CODE_W-1:0] code_q;
    logic              wr_q;

    ptimer_el0_dec u_el0 (
        .l1_aa32     (l1_aa32),
        .l2_aa32     (l2_aa32),
        .hyp_en      (hyp_en),
        .e2h         (e2h),
        .tge         (tge),
        .ns          (ns),
        .k64_el0_ten (k64_el0_ten),
        .k32_el0_ten (k32_el0_ten),
        .h64_el1_cen (h64_el1_cen),
        .h64_el1_ten (h64_el1_ten),
        .h64_el0_ten (h64_el0_ten),
        .h32_el1_cen (h32_el1_cen),
        .verdict     (v_l0)
    );

    ptimer_el1_dec u_el1 (
        .l2_aa32     (l2_aa32),
        .l3_aa32     (l3_aa32),
        .l3_present  (l3_present),
        .hyp_en      (hyp_en),
        .e2h         (e2h),
        .ns          (ns),
        .h64_el1_cen (h64_el1_cen),
        .h64_el1_ten (h64_el1_ten),
        .h32_el1_cen (h32_el1_cen),
        .verdict     (v_l1)
    );

    ptimer_upper_dec u_up (
        .at_l3      (cur_el[0]),
        .l3_aa32    (l3_aa32),
        .l3_present (l3_present),
        .ns         (ns),
        .verdict    (v_up)
    );

    always_comb begin
        unique case (cur_el)
            2'd0:    v_next = v_l0;
            2'd1:    v_next = v_l1;
            default: v_next = v_up;
        endcase
    end

    // State register: next state is always the decision for the current inputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OC_UNDEF;
            code_q  <= CODE_NONE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= v_next.oc;
            code_q  <= v_next.code;
            wr_q    <= wr_in;
        end
    end

    // Output process: one-hot view of the state.
    for (genvar g = 0; g < NUM_OC; g++) begin : g_onehot
        assign outcome[g] = (state_q == outcome_e'(g));
    end

    assign trap_code = code_q;
    assign wr_out    = wr_q;

endmodule

// File: rtl/ptimer_trap_checker.sv
module ptimer_trap_checker
    import ptimer_trap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cur_el,
    input logic              l2_aa32,
    input logic              l3_aa32,
    input logic              l3_present,
    input logic              hyp_en,
    input logic              ns,
    input logic              h32_el1_cen,
    input logic              wr_in,
    input logic [NUM_OC-1:0] outcome,
    input logic [CODE_W-1:0] trap_code,
    input logic              wr_out
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(outcome) == 1); // R10

    AST_CODE_ZERO_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome[2:0] == 3'b000) |-> (trap_code == '0)); // R10

    AST_DIR_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in |=> wr_out); // R11

    AST_DIR_DELAY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_in |=> !wr_out); // R11

    AST_L3_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd3 && !ns) |=> outcome[5]); // R9

    AST_L3_NONSECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd3 && ns) |=> outcome[6]); // R9

    AST_L2_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd2 && !(l3_present && l3_aa32)) |=> outcome[4]); // R9

    AST_L1_HYP32_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd1 && hyp_en && l2_aa32 && !h32_el1_cen)
        |=> (outcome[2] && trap_code == CODE_W'(3))); // R6

endmodule

bind ptimer_trap_decoder ptimer_trap_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_el      (cur_el),
    .l2_aa32     (l2_aa32),
    .l3_aa32     (l3_aa32),
    .l3_present  (l3_present),
    .hyp_en      (hyp_en),
    .ns          (ns),
    .h32_el1_cen (h32_el1_cen),
    .wr_in       (wr_in),
    .outcome     (outcome),
    .trap_code   (trap_code),
    .wr_out      (wr_out)
);

// File: tb/ptimer_trap_decoder_bench.sv
module ptimer_trap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] vec = '0;
    logic [8:0]  outcome;
    logic [7:0]  trap_code;
    logic        wr_out;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #5 clk = ~clk;

    // Vector bits: [16:15] level, 14 l1_aa32, 13 l2_aa32, 12 l3_aa32, 11 l3_present,
    // 10 hyp_en, 9 e2h, 8 tge, 7 ns, 6 k64_el0_ten, 5 k32_el0_ten, 4 h64_el1_cen,
    // 3 h64_el1_ten, 2 h64_el0_ten, 1 h32_el1_cen, 0 wr_in
    ptimer_trap_decoder u_ptimer_trap_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_el      (vec[16:15]),
        .l1_aa32     (vec[14]),
        .l2_aa32     (vec[13]),
        .l3_aa32     (vec[12]),
        .l3_present  (vec[11]),
        .hyp_en      (vec[10]),
        .e2h         (vec[9]),
        .tge         (vec[8]),
        .ns          (vec[7]),
        .k64_el0_ten (vec[6]),
        .k32_el0_ten (vec[5]),
        .h64_el1_cen (vec[4]),
        .h64_el1_ten (vec[3]),
        .h64_el0_ten (vec[2]),
        .h32_el1_cen (vec[1]),
        .wr_in       (vec[0]),
        .outcome     (outcome),
        .trap_code   (trap_code),
        .wr_out      (wr_out)
    );

    function automatic void expect_of(input logic [16:0] v, output int idx,
                                      output logic [7:0] cd, output string tag);
        logic [1:0] el = v[16:15];
        logic a1 = v[14], a2 = v[13], a3 = v[12], p3 = v[11], he = v[10];
        logic eh = v[9], tg = v[8], nsb = v[7], k64 = v[6], k32 = v[5];
        logic cen = v[4], ten1 = v[3], ten0 = v[2], c32 = v[1];
        logic h64 = he & ~a2;
        logic h32 = he & a2;
        logic hostm = he & eh & tg;
        cd = 8'h00;
        if (el == 2'd0) begin
            if (!a1 && !hostm && !k64) begin
                idx = (h64 && tg) ? 1 : 0; cd = 8'h03; tag = "R2";
            end else if (a1 && !k32) begin
                tag = "R3";
                if (h64 && tg)      begin idx = 1; cd = 8'h03; end
                else if (h32 && tg) begin idx = 2; cd = 8'h00; end
                else                idx = 3;
            end else if (h64 && !eh && !cen) begin
                idx = 1; cd = 8'h03; tag = "R4";
            end else if (h64 && eh && !tg && !ten1) begin
                idx = 1; cd = 8'h03; tag = "R5";
            end else if (h64 && eh && tg && !ten0) begin
                idx = 1; cd = 8'h03; tag = "R5";
            end else if (h32 && !c32) begin
                idx = 2; cd = 8'h03; tag = "R6";
            end else begin
                tag = "R7";
                if (h64 && eh && tg) idx = nsb ? 8 : 7;
                else                 idx = 4;
            end
        end else if (el == 2'd1) begin
            if (h64 && !eh && !cen)     begin idx = 1; cd = 8'h03; tag = "R4"; end
            else if (h64 && eh && !ten1) begin idx = 1; cd = 8'h03; tag = "R5"; end
            else if (h32 && !c32)       begin idx = 2; cd = 8'h03; tag = "R6"; end
            else begin
                tag = "R8";
                idx = (p3 && a3) ? (nsb ? 6 : 5) : 4;
            end
        end else if (el == 2'd2) begin
            tag = "R9"; idx = (p3 && a3) ? 6 : 4;
        end else begin
            tag = "R9"; idx = nsb ? 6 : 5;
        end
    endfunction

    task automatic check_bits(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (vector %0h)", tag, act, exp, vec);
        end
    endtask

    task automatic apply(input logic [16:0] v, input string force_tag);
        int idx;
        logic [7:0] cd;
        string tag;
        @(negedge clk);
        vec = v;
        @(negedge clk);
        expect_of(v, idx, cd, tag);
        if (force_tag != "") tag = force_tag;
        check_bits(tag, {15'd0, trap_code, outcome}, {15'd0, cd, 9'(1) << idx});
        // R10: one bit set, zero code without a trap
        check_bits("R10", ($countones(outcome) == 1 && (outcome[2:0] != 0 || trap_code == 0)) ? 32'd1 : 32'd0, 32'd1);
        // R11: direction passes through, one cycle late
        check_bits("R11", {31'd0, wr_out}, {31'd0, v[0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd13579));
        vec = 17'h1FFFF;
        #12;
        // R1: reset state
        check_bits("R1", {15'd0, trap_code, outcome}, {15'd0, 8'h00, 9'h008});
        check_bits("R1", {31'd0, wr_out}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: before any new edge the reset state still holds
        check_bits("R1", {23'd0, outcome}, 32'h008);

        // R2: level 0, 64-bit kernel, enable clear, no hypervisor -> level 1
        apply({2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, "R2");
        // R2: 64-bit hypervisor with tge=1, e2h=0 -> level 2
        apply({2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, "R2");
        // R3: 32-bit kernel, 32-bit hypervisor with tge -> code 0
        apply({2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, "R3");
        // R3: no hypervisor -> undefined
        apply({2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, "R3");
        // R4: level 1, e2h=0, counter enable clear
        apply({2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, "R4");
        // R5: level 0 host mode, level-0 timer enable clear
        apply({2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, "R5");
        // R6: level 0, 32-bit hypervisor counter enable clear
        apply({2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, "R6");
        // R7: host mode permitted, ns=0 and ns=1
        apply({2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, "R7");
        apply({2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, "R7");
        // R8: level 1 with 32-bit level 3, secure
        apply({2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, "R8");
        // R9: level 2 with 32-bit level 3, and level 3 non-secure
        apply({2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, "R9");
        apply({2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, "R9");
        // R12: R2 and R4 both match at level 0; R2 (level-1 trap) wins
        apply({2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, "R12");
        // R12: R4 and R6-like enables clear at level 1; R4 wins
        apply({2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, "R12");

        for (int i = 0; i < 3000; i++) begin
            apply(17'($urandom), "");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule